// File: doc/BRIEF.md
# Pattern and Nametable Page Mapper

This block translates the video bus address range $0000-$2FFF into either a character-ROM address or an access to the console's internal 2 KB nametable RAM. The range is cut into twelve 1 KB slices. Each slice has an 8-bit page register, and the CPU loads these registers with writes to $8000-$DFFF. Each register answers to an $800-byte window of that range. The translation is combinational from the registers: the video address picks a slice, and the slice's page value decides the target.

Page values below $E0 select that 1 KB page of a character ROM of up to 256 KB. Page values $E0-$FF can instead be sent to the internal nametable RAM, with the low bit choosing half A or half B. This lets that RAM act as writable pattern memory. The eight pattern slices obey two disable flags, one for $0000-$0FFF and one for $1000-$1FFF. Both flags sit in a control register at $E800-$EFFF. The four nametable slices redirect without any condition. Writes from the video bus reach the RAM only through redirected slices.

Top module: `vid_page_mapper`

## Requirements
- R1: After reset all twelve page registers and both disable flags are 0, so every slice maps to ROM page 0.
- R2: A CPU write whose address bits 15:11 equal 16+i, for i from 0 to 11, loads slice i's page register from the data byte, whatever address bits 10:0 are. Writes to other addresses leave every page register unchanged.
- R3: When a mapped slice holds a page value below $E0, the block asserts rom_sel and drives rom_addr = {page, vid_addr[9:0]}.
- R4: A slice in $0000-$0FFF with a page value of $E0-$FF and the low disable flag at 0 asserts nt_sel. It drives nt_half = page bit 0 (0 selects A, 1 selects B) and nt_addr = vid_addr[9:0].
- R5: A slice in $1000-$1FFF with a page value of $E0-$FF and the high disable flag at 0 redirects in the same way as R4.
- R6: When the flag governing a pattern slice is 1, page values $E0-$FF address ROM with rom_addr = {page, vid_addr[9:0]}, which is one of the last 32 ROM pages.
- R7: Slices in $2000-$2FFF redirect page values $E0-$FF to the nametable RAM whatever the flags hold.
- R8: A CPU write with address bits 15:11 equal to 29 ($E800-$EFFF) loads the low disable flag from data bit 6 and the high disable flag from data bit 7. Other data bits and other addresses do not change the flags.
- R9: Video addresses $3000-$3FFF assert neither rom_sel, nt_sel nor nt_we.
- R10: nt_we equals vid_we while a slice is redirected and is 0 otherwise. A write aimed at a ROM slice has no effect.
- R11: rom_sel and nt_sel are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 5 | CPU address bits 15:11 |
| cpu_wdata | input | 8 | CPU write data |
| vid_addr | input | 14 | Video bus address |
| vid_we | input | 1 | Video bus write request |
| rom_sel | output | 1 | Access goes to character ROM |
| rom_addr | output | 18 | Character ROM byte address |
| nt_sel | output | 1 | Access goes to internal nametable RAM |
| nt_half | output | 1 | RAM half: 0 = A, 1 = B |
| nt_addr | output | 10 | Byte address inside the RAM half |
| nt_we | output | 1 | Write enable to the nametable RAM |

## Verification
The bench probes the edge between $DF and $E0. A design with an off-by-one threshold would send page $DF to RAM or page $E0 to ROM. It sets each disable flag on its own and checks that each flag controls only its own half of pattern space. A swapped flag bit would redirect the wrong slices. It also checks that the nametable slices keep redirecting with both flags set. It writes to register windows at offsets other than the base address, and writes to neighbouring addresses such as $E000 and $F000. A decoder that used the low address bits, or was too wide, would then load the wrong register. Video writes go to ROM slices and to the unmapped $3000 range, where a leaky write enable would corrupt the RAM.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  // Role of a 1 KB slice within the mapped video space.
  typedef enum logic [1:0] {
    SK_PAT_LO,
    SK_PAT_HI,
    SK_NAMETBL,
    SK_NONE
  } slice_kind_e;

  // Class of slice idx: pattern slices come first, low half then high half,
  // then nametable slices up to total; anything past total is unmapped.
  function automatic slice_kind_e kind_of(int unsigned idx, int unsigned per_half,
                                          int unsigned total);
    if (idx < per_half) return SK_PAT_LO;
    if (idx < 2 * per_half) return SK_PAT_HI;
    if (idx < total) return SK_NAMETBL;
    return SK_NONE;
  endfunction

  // Redirection rule: a high page goes to nametable RAM unless the flag
  // governing its pattern half is set; nametable slices ignore the flags.
  function automatic logic redirect_rule(slice_kind_e kind, logic high_page,
                                         logic lo_off, logic hi_off);
    case (kind)
      SK_PAT_LO:  return high_page && !lo_off;
      SK_PAT_HI:  return high_page && !hi_off;
      SK_NAMETBL: return high_page;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vpm_page_regs.sv
module vpm_page_regs #(
  parameter int NUM_SLICES = 12,
  parameter int PAGE_W     = 8,
  parameter int SEL_W      = 5,
  parameter logic [SEL_W-1:0] PAGE_SEL_BASE = 5'h10,
  parameter logic [SEL_W-1:0] FLAG_SEL      = 5'h1D,
  parameter int LO_FLAG_BIT = 6,
  parameter int HI_FLAG_BIT = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_wr,
  input  logic [SEL_W-1:0]                  cpu_addr_hi,
  input  logic [PAGE_W-1:0]                 cpu_wdata,
  output logic [NUM_SLICES-1:0][PAGE_W-1:0] page_q,
  output logic                              lo_off_q,
  output logic                              hi_off_q,
  output logic                              page_wr_hit,
  output logic                              flag_wr_hit
);

  logic [NUM_SLICES-1:0] slot_hit;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slot
    localparam logic [SEL_W-1:0] MY_SEL = PAGE_SEL_BASE + SEL_W'(i);

    assign slot_hit[i] = cpu_wr && (cpu_addr_hi == MY_SEL);

    always_ff @(posedge clk) begin
      if (!rst_n) page_q[i] <= '0;
      else if (slot_hit[i]) page_q[i] <= cpu_wdata;
    end
  end

  assign page_wr_hit = |slot_hit;
  assign flag_wr_hit = cpu_wr && (cpu_addr_hi == FLAG_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_off_q <= 1'b0;
      hi_off_q <= 1'b0;
    end else if (flag_wr_hit) begin
      lo_off_q <= cpu_wdata[LO_FLAG_BIT];
      hi_off_q <= cpu_wdata[HI_FLAG_BIT];
    end
  end

endmodule

// File: rtl/vpm_slice_xlate.sv
module vpm_slice_xlate
  import vpm_pkg::*;
#(
  parameter int NUM_SLICES = 12,
  parameter int PER_HALF   = 4,
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 10,
  parameter int VID_AW     = 14,
  parameter logic [PAGE_W-1:0] REDIR_BASE = 8'hE0,
  localparam int IDX_W = VID_AW - OFS_W
) (
  input  logic [NUM_SLICES-1:0][PAGE_W-1:0] page_q,
  input  logic                              lo_off,
  input  logic                              hi_off,
  input  logic [VID_AW-1:0]                 vid_addr,
  input  logic                              vid_we,
  output logic                              rom_sel,
  output logic [PAGE_W+OFS_W-1:0]           rom_addr,
  output logic                              nt_sel,
  output logic                              nt_half,
  output logic [OFS_W-1:0]                  nt_addr,
  output logic                              nt_we,
  output logic                              redirect,
  output logic                              in_range,
  output logic [IDX_W-1:0]                  slice_idx
);

  logic [PAGE_W-1:0] page;
  slice_kind_e       kind;

  assign slice_idx = vid_addr[VID_AW-1:OFS_W];

  always_comb begin
    page = '0;
    kind = SK_NONE;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (slice_idx == IDX_W'(i)) begin
        page = page_q[i];
        kind = kind_of(i, PER_HALF, NUM_SLICES);
      end
    end
  end

  assign in_range = (kind != SK_NONE);
  assign redirect = redirect_rule(kind, page >= REDIR_BASE, lo_off, hi_off);

  assign rom_sel  = in_range && !redirect;
  assign rom_addr = {page, vid_addr[OFS_W-1:0]};
  assign nt_sel   = redirect;
  assign nt_half  = page[0];
  assign nt_addr  = vid_addr[OFS_W-1:0];
  assign nt_we    = redirect && vid_we;

endmodule

// File: rtl/vid_page_mapper.sv
module vid_page_mapper #(
  parameter int NUM_SLICES = 12,
  parameter int PER_HALF   = 4,
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 10,
  parameter int VID_AW     = 14,
  parameter int SEL_W      = 5,
  parameter logic [PAGE_W-1:0] REDIR_BASE   = 8'hE0,
  parameter logic [SEL_W-1:0] PAGE_SEL_BASE = 5'h10,
  parameter logic [SEL_W-1:0] FLAG_SEL      = 5'h1D,
  localparam int ROM_AW = PAGE_W + OFS_W,
  localparam int IDX_W  = VID_AW - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [SEL_W-1:0]  cpu_addr_hi,
  input  logic [PAGE_W-1:0] cpu_wdata,
  input  logic [VID_AW-1:0] vid_addr,
  input  logic              vid_we,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              nt_sel,
  output logic              nt_half,
  output logic [OFS_W-1:0]  nt_addr,
  output logic              nt_we
);

  logic [NUM_SLICES-1:0][PAGE_W-1:0] page_q;
  logic                              lo_off;
  logic                              hi_off;
  logic                              page_wr_hit;
  logic                              flag_wr_hit;
  logic                              redirect;
  logic                              in_range;
  logic [IDX_W-1:0]                  slice_idx;

  vpm_page_regs #(
    .NUM_SLICES   (NUM_SLICES),
    .PAGE_W       (PAGE_W),
    .SEL_W        (SEL_W),
    .PAGE_SEL_BASE(PAGE_SEL_BASE),
    .FLAG_SEL     (FLAG_SEL),
    .LO_FLAG_BIT  (PAGE_W - 2),
    .HI_FLAG_BIT  (PAGE_W - 1)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_addr_hi(cpu_addr_hi),
    .cpu_wdata  (cpu_wdata),
    .page_q     (page_q),
    .lo_off_q   (lo_off),
    .hi_off_q   (hi_off),
    .page_wr_hit(page_wr_hit),
    .flag_wr_hit(flag_wr_hit)
  );

  vpm_slice_xlate #(
    .NUM_SLICES(NUM_SLICES),
    .PER_HALF  (PER_HALF),
    .PAGE_W    (PAGE_W),
    .OFS_W     (OFS_W),
    .VID_AW    (VID_AW),
    .REDIR_BASE(REDIR_BASE)
  ) u_xlate (
    .page_q   (page_q),
    .lo_off   (lo_off),
    .hi_off   (hi_off),
    .vid_addr (vid_addr),
    .vid_we   (vid_we),
    .rom_sel  (rom_sel),
    .rom_addr (rom_addr),
    .nt_sel   (nt_sel),
    .nt_half  (nt_half),
    .nt_addr  (nt_addr),
    .nt_we    (nt_we),
    .redirect (redirect),
    .in_range (in_range),
    .slice_idx(slice_idx)
  );

endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
  parameter int NUM_SLICES = 12,
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 10,
  parameter int VID_AW     = 14,
  parameter int SEL_W      = 5,
  parameter logic [PAGE_W-1:0] REDIR_BASE   = 8'hE0,
  parameter logic [SEL_W-1:0] PAGE_SEL_BASE = 5'h10,
  localparam int ROM_AW = PAGE_W + OFS_W,
  localparam int IDX_W  = VID_AW - OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  cpu_addr_hi,
  input logic [PAGE_W-1:0] cpu_wdata,
  input logic [VID_AW-1:0] vid_addr,
  input logic              vid_we,
  input logic              rom_sel,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              nt_sel,
  input logic [OFS_W-1:0]  nt_addr,
  input logic              nt_we,
  input logic              page_wr_hit,
  input logic              flag_wr_hit,
  input logic              redirect,
  input logic              in_range,
  input logic [IDX_W-1:0]  slice_idx
);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && nt_sel));

  assert_nt_write_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nt_we |-> (nt_sel && vid_we));

  assert_nt_write_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_sel && vid_we) |-> nt_we);

  assert_unmapped_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vid_addr) >= (NUM_SLICES << OFS_W)) |-> (!rom_sel && !nt_sel && !nt_we));

  assert_mapped_has_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |-> (rom_sel || nt_sel));

  assert_redirect_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (nt_sel && nt_addr == vid_addr[OFS_W-1:0]));

  assert_decode_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_hit |-> !page_wr_hit);

  assert_low_page_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr_hit && cpu_wdata < REDIR_BASE) |=>
      ((SEL_W'(slice_idx) + PAGE_SEL_BASE) != $past(cpu_addr_hi)) ||
      (rom_sel && rom_addr[ROM_AW-1:OFS_W] == $past(cpu_wdata)));

endmodule

bind vid_page_mapper vpm_checker #(
  .NUM_SLICES   (NUM_SLICES),
  .PAGE_W       (PAGE_W),
  .OFS_W        (OFS_W),
  .VID_AW       (VID_AW),
  .SEL_W        (SEL_W),
  .REDIR_BASE   (REDIR_BASE),
  .PAGE_SEL_BASE(PAGE_SEL_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr_hi(cpu_addr_hi),
  .cpu_wdata  (cpu_wdata),
  .vid_addr   (vid_addr),
  .vid_we     (vid_we),
  .rom_sel    (rom_sel),
  .rom_addr   (rom_addr),
  .nt_sel     (nt_sel),
  .nt_addr    (nt_addr),
  .nt_we      (nt_we),
  .page_wr_hit(page_wr_hit),
  .flag_wr_hit(flag_wr_hit),
  .redirect   (redirect),
  .in_range   (in_range),
  .slice_idx  (slice_idx)
);

// File: tb/vid_page_mapper_tb.sv
module vid_page_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [4:0]  cpu_addr_hi = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] vid_addr = '0;
  logic        vid_we = 1'b0;
  logic        rom_sel;
  logic [17:0] rom_addr;
  logic        nt_sel;
  logic        nt_half;
  logic [9:0]  nt_addr;
  logic        nt_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side view of the register state, kept from the CPU writes it makes.
  logic [7:0] mdl_page [12];
  logic       mdl_lo = 1'b0;
  logic       mdl_hi = 1'b0;

  always #10 clk = ~clk;

  vid_page_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr_hi(cpu_addr_hi),
    .cpu_wdata(cpu_wdata), .vid_addr(vid_addr), .vid_we(vid_we),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .nt_sel(nt_sel),
    .nt_half(nt_half), .nt_addr(nt_addr), .nt_we(nt_we)
  );

  task automatic cpu_write(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    cpu_wr = 1'b1;
    cpu_addr_hi = addr[15:11];
    cpu_wdata = data;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (addr >= 16'h8000 && addr < 16'hE000)
      mdl_page[(int'(addr) - 32'h8000) / 2048] = data;
    if (addr >= 16'hE800 && addr < 16'hF000) begin
      mdl_lo = data[6];
      mdl_hi = data[7];
    end
  endtask

  // Drive a video access and compare every output with the expected mapping.
  task automatic check_vid(input logic [13:0] va, input logic we, input string tag);
    int idx;
    logic [7:0] pg;
    logic gate, e_rom, e_nt, e_half, e_we;
    logic [17:0] e_ra;
    bit bad;
    vid_addr = va;
    vid_we = we;
    #2;
    idx = int'(va) / 1024;
    e_rom = 0; e_nt = 0; e_half = 0; e_ra = '0;
    if (idx < 12) begin
      pg = mdl_page[idx];
      gate = (idx < 4) ? mdl_lo : ((idx < 8) ? mdl_hi : 1'b0);
      if (pg >= 8'd224 && !gate) begin
        e_nt = 1; e_half = pg[0];
      end else begin
        e_rom = 1; e_ra = {pg, va[9:0]};
      end
    end
    e_we = e_nt && we;
    bad = (rom_sel !== e_rom) || (nt_sel !== e_nt) || (nt_we !== e_we) ||
          (e_rom && rom_addr !== e_ra) ||
          (e_nt && (nt_half !== e_half || nt_addr !== va[9:0])) ||
          (rom_sel && nt_sel);
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s va=%h: act rom=%b ra=%h nt=%b half=%b na=%h we=%b exp rom=%b ra=%h nt=%b half=%b na=%h we=%b",
               tag, va, rom_sel, rom_addr, nt_sel, nt_half, nt_addr, nt_we,
               e_rom, e_ra, e_nt, e_half, va[9:0], e_we);
    end
    vid_we = 1'b0;
  endtask

  task automatic t_reset();
    check_vid(14'h0000, 0, "R1 reset slice0");
    check_vid(14'h1555, 0, "R1 reset slice5");
    check_vid(14'h2FFF, 0, "R1 reset slice11");
  endtask

  task automatic t_rom_pages();
    for (int i = 0; i < 12; i++)
      cpu_write(16'h8000 + 16'(i * 16'h800) + 16'((i * 37) & 16'h7FF), 8'(i * 17 + 3));
    for (int i = 0; i < 12; i++)
      check_vid(14'(i * 1024 + 300 + i), 0, "R2 R3 page per slice");
    cpu_write(16'h8000, 8'hDF);
    check_vid(14'h03FF, 0, "R3 boundary DF stays ROM");
  endtask

  task automatic t_lower_redirect();
    cpu_write(16'h8800, 8'hE0);
    cpu_write(16'h9FFF, 8'hE1);
    check_vid(14'h0412, 0, "R4 E0 half A");
    check_vid(14'h0C7F, 0, "R4 E1 half B");
  endtask

  task automatic t_upper_redirect();
    cpu_write(16'hA800, 8'hE2);
    cpu_write(16'hB800, 8'hFF);
    check_vid(14'h1401, 0, "R5 E2 half A");
    check_vid(14'h1FFE, 0, "R5 FF half B");
  endtask

  task automatic t_flag_gate();
    cpu_write(16'hE9AB, 8'h7F);  // bit6 set, bit7 clear, low bits noise
    check_vid(14'h0412, 0, "R6 R8 low flag ROM top page");
    check_vid(14'h1401, 0, "R8 high half unaffected");
    cpu_write(16'hEFFF, 8'h80);
    check_vid(14'h0C7F, 0, "R8 low flag cleared");
    check_vid(14'h1FFE, 0, "R6 high flag ROM top page");
    cpu_write(16'hE000, 8'hFF);
    cpu_write(16'hF000, 8'hFF);
    cpu_write(16'h7800, 8'hFF);
    check_vid(14'h1FFE, 0, "R8 flags unchanged by other addr");
    check_vid(14'h0C7F, 0, "R2 pages unchanged by other addr");
  endtask

  task automatic t_nametable();
    cpu_write(16'hE800, 8'hC0);
    cpu_write(16'hC000, 8'hE0);
    cpu_write(16'hCC00, 8'hE3);
    cpu_write(16'hD000, 8'hFE);
    cpu_write(16'hD800, 8'h10);
    check_vid(14'h2000, 0, "R7 nt slice8 half A");
    check_vid(14'h27FF, 0, "R7 nt slice9 half B");
    check_vid(14'h2A00, 0, "R7 nt slice10 half A");
    check_vid(14'h2D55, 0, "R7 nt slice11 ROM page");
  endtask

  task automatic t_unmapped();
    check_vid(14'h3000, 1, "R9 R11 unmapped low");
    check_vid(14'h3FFF, 1, "R9 unmapped high");
  endtask

  task automatic t_write_gate();
    check_vid(14'h2D00, 1, "R10 ROM write ignored");
    check_vid(14'h2400, 1, "R10 RAM write passes");
    check_vid(14'h0C00, 1, "R10 gated pattern slice to ROM");
  endtask

  initial begin
    for (int i = 0; i < 12; i++) mdl_page[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rom_pages();
    t_lower_redirect();
    t_upper_redirect();
    t_flag_gate();
    t_nametable();
    t_unmapped();
    t_write_gate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule